// File: doc/BRIEF.md
# SMT Commit Thread Selector

In a multithreaded out-of-order core the retire stage must decide, for each commit slot, which hardware thread may retire the instruction at the head of its reorder buffer. This selector makes that decision. For each thread it receives a status code, a head-ready flag, a buffer-empty flag and the sequence number of the head instruction. A two-bit policy input chooses one of three arbitration schemes. The result is a thread index together with a valid bit.

The selection is combinational, so the commit loop can query it within the cycle in which it needs the answer. The only storage is the rotating priority order used by the round-robin policy. That order changes on the clock edge after a query that produced a round-robin pick. The aggressive policy arbitrates exactly like oldest-ready; the commit loop simply queries it more often in a cycle.

Top module: `smt_commit_selector`

## Requirements
- R1: Status codes are 0 Idle, 1 Running, 2 Squashing, 3 TrapPending, 4 FetchTrapPending, and 5 to 7 are unused. Only codes 0, 1 and 4 make a thread eligible, and the selector never reports any other thread.
- R2: Policy codes are 0 aggressive, 1 round-robin, 2 oldest-ready and 3 oldest-ready. Codes 0 and 3 arbitrate exactly as code 2 does.
- R3: After reset the round-robin order is thread 0 first, then ascending to thread N-1 last.
- R4: Under round-robin the selector walks the order from its front and reports the first eligible thread whose head-ready flag is set.
- R5: When `query_i` is high during a round-robin pick with `sel_valid_o` high, the picked thread moves to the back of the order on the next rising clock edge. The other threads keep their relative order. With every thread ready, successive queries serve threads 0,1,...,N-1 and then repeat.
- R6: The order does not change in a cycle with `query_i` low, with no valid pick, or with a policy other than round-robin.
- R7: Under oldest-ready a thread qualifies only when it is eligible, its head is ready and its buffer is not empty. Of the qualifying threads, the one whose head sequence number is smallest is reported.
- R8: When qualifying threads have equal head sequence numbers under oldest-ready, the lowest thread index wins.
- R9: When no thread qualifies, `sel_valid_o` is 0 and `sel_tid_o` is 0.
- R10: With N_THREADS = 1 the selector reports thread 0 whenever its status is eligible, whatever the head-ready and empty flags are, under every policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| query_i | input | 1 | Commit slot consumes the current selection |
| policy_i | input | 2 | Arbitration policy code |
| status_i | input | N_THREADS x 3 | Per-thread status code |
| head_ready_i | input | N_THREADS | Per-thread head instruction ready to retire |
| rob_empty_i | input | N_THREADS | Per-thread reorder buffer empty |
| head_seq_i | input | N_THREADS x SEQ_W | Per-thread head sequence number |
| sel_valid_o | output | 1 | A thread was selected |
| sel_tid_o | output | TID_W | Selected thread index |

## Verification
The hardest condition to reach is a round-robin order that is no longer a plain rotation. That order only appears after picks that skip threads which are not ready, and it is hidden inside the block. The stimulus reaches it with a run of queries in which one thread is held not-ready, so that thread stays ahead while the others pass it. A bench model of the order then predicts every later pick. The order must also survive oldest-ready queries and idle cycles unchanged, and this is shown by the round-robin picks that follow them. Age ordering is covered by random sequence numbers, statuses and flags, with the expected winner computed in the bench.

// File: rtl/csel_pkg.sv
package csel_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RUN    = 3'd1,
    ST_SQUASH = 3'd2,
    ST_TRAP   = 3'd3,
    ST_FTRAP  = 3'd4
  } thr_status_e;

  typedef enum logic [1:0] {
    POL_GREEDY  = 2'd0,
    POL_ROTATE  = 2'd1,
    POL_AGE     = 2'd2,
    POL_AGE_ALT = 2'd3
  } commit_pol_e;

  function automatic logic status_can_commit(input logic [2:0] st);
    return (st == ST_IDLE) || (st == ST_RUN) || (st == ST_FTRAP);
  endfunction
endpackage

// File: rtl/csel_rr_order.sv
module csel_rr_order #(
  parameter int N_THREADS = 4,
  parameter int TID_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_THREADS-1:0] cand_i,
  input  logic                 advance_i,
  output logic                 hit_o,
  output logic [TID_W-1:0]     tid_o
);
  logic [TID_W-1:0] order_q [N_THREADS];
  logic [TID_W-1:0] order_d [N_THREADS];
  logic [TID_W-1:0] pos;

  always_comb begin
    hit_o = 1'b0;
    pos   = '0;
    for (int p = 0; p < N_THREADS; p++) begin
      if (!hit_o && cand_i[order_q[p]]) begin
        hit_o = 1'b1;
        pos   = TID_W'(p);
      end
    end
    tid_o = order_q[pos];
  end

  always_comb begin
    for (int p = 0; p < N_THREADS; p++) begin
      if (TID_W'(p) < pos)          order_d[p] = order_q[p];
      else if (p < N_THREADS - 1)   order_d[p] = order_q[(p < N_THREADS - 1) ? p + 1 : p];
      else                          order_d[p] = tid_o;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < N_THREADS; p++) order_q[p] <= TID_W'(p);
    end else if (advance_i && hit_o) begin
      for (int p = 0; p < N_THREADS; p++) order_q[p] <= order_d[p];
    end
  end
endmodule

// File: rtl/csel_age_pick.sv
module csel_age_pick #(
  parameter int N_THREADS = 4,
  parameter int SEQ_W     = 16,
  parameter int TID_W     = 2
) (
  input  logic [N_THREADS-1:0]            cand_i,
  input  logic [N_THREADS-1:0][SEQ_W-1:0] seq_i,
  output logic                            hit_o,
  output logic [TID_W-1:0]                tid_o
);
  logic [SEQ_W-1:0] best;

  always_comb begin
    hit_o = 1'b0;
    tid_o = '0;
    best  = '0;
    for (int t = 0; t < N_THREADS; t++) begin
      if (cand_i[t] && (!hit_o || seq_i[t] < best)) begin
        hit_o = 1'b1;
        best  = seq_i[t];
        tid_o = TID_W'(t);
      end
    end
  end
endmodule

// File: rtl/smt_commit_selector.sv
module smt_commit_selector #(
  parameter int N_THREADS = 4,
  parameter int SEQ_W     = 16,
  parameter int TID_W     = (N_THREADS > 1) ? $clog2(N_THREADS) : 1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            query_i,
  input  logic [1:0]                      policy_i,
  input  logic [N_THREADS-1:0][2:0]       status_i,
  input  logic [N_THREADS-1:0]            head_ready_i,
  input  logic [N_THREADS-1:0]            rob_empty_i,
  input  logic [N_THREADS-1:0][SEQ_W-1:0] head_seq_i,
  output logic                            sel_valid_o,
  output logic [TID_W-1:0]                sel_tid_o
);
  import csel_pkg::*;

  logic [N_THREADS-1:0] elig;

  for (genvar t = 0; t < N_THREADS; t++) begin : g_elig
    assign elig[t] = status_can_commit(status_i[t]);
  end

  if (N_THREADS == 1) begin : g_single
    assign sel_valid_o = elig[0];
    assign sel_tid_o   = '0;
  end else begin : g_multi
    logic             use_rr;
    logic             rr_hit, age_hit;
    logic [TID_W-1:0] rr_tid, age_tid;

    assign use_rr = (policy_i == POL_ROTATE);

    csel_rr_order #(.N_THREADS(N_THREADS), .TID_W(TID_W)) u_rr (
      .clk       (clk),
      .rst       (rst),
      .cand_i    (elig & head_ready_i),
      .advance_i (query_i && use_rr),
      .hit_o     (rr_hit),
      .tid_o     (rr_tid)
    );

    csel_age_pick #(.N_THREADS(N_THREADS), .SEQ_W(SEQ_W), .TID_W(TID_W)) u_age (
      .cand_i (elig & head_ready_i & ~rob_empty_i),
      .seq_i  (head_seq_i),
      .hit_o  (age_hit),
      .tid_o  (age_tid)
    );

    always_comb begin
      sel_valid_o = use_rr ? rr_hit : age_hit;
      sel_tid_o   = '0;
      if (sel_valid_o) sel_tid_o = use_rr ? rr_tid : age_tid;
    end
  end
endmodule

// File: rtl/smt_commit_selector_chk.sv
module smt_commit_selector_chk #(
  parameter int N_THREADS = 4,
  parameter int SEQ_W     = 16,
  parameter int TID_W     = 2
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            query_i,
  input logic [1:0]                      policy_i,
  input logic [N_THREADS-1:0][2:0]       status_i,
  input logic [N_THREADS-1:0]            head_ready_i,
  input logic [N_THREADS-1:0]            rob_empty_i,
  input logic [N_THREADS-1:0][SEQ_W-1:0] head_seq_i,
  input logic                            sel_valid_o,
  input logic [TID_W-1:0]                sel_tid_o
);
  logic sel_ok_status;
  logic older_exists;
  logic any_age;
  logic past_ok;

  always_comb begin
    sel_ok_status = 1'b0;
    older_exists  = 1'b0;
    any_age       = 1'b0;
    for (int t = 0; t < N_THREADS; t++) begin
      logic q;
      q = (status_i[t] == 3'd0 || status_i[t] == 3'd1 || status_i[t] == 3'd4)
          && head_ready_i[t] && !rob_empty_i[t];
      if (TID_W'(t) == sel_tid_o)
        sel_ok_status = (status_i[t] == 3'd0 || status_i[t] == 3'd1 || status_i[t] == 3'd4);
      if (q) any_age = 1'b1;
      if (q && head_seq_i[t] < head_seq_i[sel_tid_o]) older_exists = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assert_eligible_only_R1: assert property (@(posedge clk) disable iff (rst)
    sel_valid_o |-> sel_ok_status);

  assert_oldest_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (N_THREADS > 1 && policy_i != 2'd1 && sel_valid_o) |-> !older_exists);

  assert_none_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (N_THREADS > 1 && policy_i != 2'd1 && !any_age) |-> (!sel_valid_o && sel_tid_o == '0));

  assert_order_held_R6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(query_i) && $stable(policy_i) && $stable(status_i)
     && $stable(head_ready_i) && $stable(rob_empty_i) && $stable(head_seq_i))
    |-> ($stable(sel_valid_o) && $stable(sel_tid_o)));
endmodule

bind smt_commit_selector smt_commit_selector_chk #(
  .N_THREADS(N_THREADS), .SEQ_W(SEQ_W), .TID_W(TID_W)
) u_chk (
  .clk(clk), .rst(rst), .query_i(query_i), .policy_i(policy_i),
  .status_i(status_i), .head_ready_i(head_ready_i), .rob_empty_i(rob_empty_i),
  .head_seq_i(head_seq_i), .sel_valid_o(sel_valid_o), .sel_tid_o(sel_tid_o)
);

// File: tb/smt_commit_selector_bench.sv
module smt_commit_selector_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int SW = 16;
  localparam int NV = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic query_i = 1'b0;
  logic [1:0] policy_i = 2'd1;
  logic [N-1:0][2:0] status_i = '0;
  logic [N-1:0] head_ready_i = '0;
  logic [N-1:0] rob_empty_i = '0;
  logic [N-1:0][SW-1:0] head_seq_i = '0;
  logic sel_valid_o;
  logic [1:0] sel_tid_o;

  logic [0:0][2:0] s1_status = '0;
  logic [0:0] s1_ready = '0;
  logic [0:0] s1_empty = '0;
  logic [0:0][SW-1:0] s1_seq = '0;
  logic s1_valid;
  logic [0:0] s1_tid;

  int checks = 0;
  int errors = 0;
  int rr_q [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  smt_commit_selector #(.N_THREADS(N), .SEQ_W(SW)) u_smt_commit_selector (
    .clk(clk), .rst(rst), .query_i(query_i), .policy_i(policy_i),
    .status_i(status_i), .head_ready_i(head_ready_i), .rob_empty_i(rob_empty_i),
    .head_seq_i(head_seq_i), .sel_valid_o(sel_valid_o), .sel_tid_o(sel_tid_o));

  smt_commit_selector #(.N_THREADS(1), .SEQ_W(SW)) u_single (
    .clk(clk), .rst(rst), .query_i(query_i), .policy_i(policy_i),
    .status_i(s1_status), .head_ready_i(s1_ready), .rob_empty_i(s1_empty),
    .head_seq_i(s1_seq), .sel_valid_o(s1_valid), .sel_tid_o(s1_tid));

  // policy, status, ready, empty, seq, expected valid, expected tid
  localparam logic [1:0]  V_POL [NV] = '{2'd2, 2'd2, 2'd0, 2'd2, 2'd2,
                                         2'd2, 2'd1, 2'd1, 2'd3, 2'd2};
  localparam logic [11:0] V_ST  [NV] = '{12'h249, 12'h289, 12'h2C9, 12'h249, 12'h249,
                                         12'h492, 12'h249, 12'h80B, 12'h249, 12'hFFF};
  localparam logic [3:0]  V_RDY [NV] = '{4'hF, 4'hF, 4'hF, 4'hE, 4'hF,
                                         4'hF, 4'hC, 4'hF, 4'hF, 4'hF};
  localparam logic [3:0]  V_EMP [NV] = '{4'h0, 4'h0, 4'h0, 4'h0, 4'h4,
                                         4'h0, 4'h0, 4'h0, 4'h0, 4'h0};
  localparam logic [63:0] V_SEQ [NV] = '{64'h0028_000A_001E_0014, 64'h0028_000A_001E_0014,
                                         64'h0028_000A_001E_0014, 64'h0005_0005_0005_0005,
                                         64'h0028_000A_001E_0014, 64'h0028_000A_001E_0014,
                                         64'h0028_000A_001E_0014, 64'h0028_000A_001E_0014,
                                         64'h0001_0009_0008_0007, 64'h0028_000A_001E_0014};
  localparam logic        V_VAL [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
                                         1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam logic [1:0]  V_TID [NV] = '{2'd2, 2'd0, 2'd0, 2'd1, 2'd0,
                                         2'd0, 2'd2, 2'd1, 2'd3, 2'd0};
  localparam string       V_REQ [NV] = '{"R7", "R1", "R2", "R8", "R7",
                                         "R9", "R4", "R1", "R2", "R9"};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rr_rotate(input int tid);
    int pos = 0;
    for (int p = 0; p < N; p++) if (rr_q[p] == tid) pos = p;
    for (int p = pos; p < N - 1; p++) rr_q[p] = rr_q[p+1];
    rr_q[N-1] = tid;
  endtask

  function automatic int rr_expect(input logic [N-1:0] rdy);
    for (int p = 0; p < N; p++) if (rdy[rr_q[p]]) return rr_q[p];
    return -1;
  endfunction

  // one round-robin query with all running, given ready mask
  task automatic rr_step(input string req, input logic [N-1:0] rdy, input logic q);
    int e;
    @(negedge clk);
    policy_i = 2'd1; status_i = 12'h249; head_ready_i = rdy; rob_empty_i = '0; query_i = q;
    #1;
    e = rr_expect(rdy);
    check(req, sel_tid_o, (e < 0) ? 0 : e);
    check(req, sel_valid_o, (e < 0) ? 0 : 1);
    if (q && e >= 0) rr_rotate(e);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int p = 0; p < N; p++) rr_q[p] = p;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R3: reset order puts thread 0 first
    policy_i = 2'd1; status_i = 12'h249; head_ready_i = 4'hF;
    #1;
    check("R3", sel_valid_o, 1);
    check("R3", sel_tid_o, 0);

    // table walk, query low so the order is untouched
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      query_i = 1'b0; policy_i = V_POL[i]; status_i = V_ST[i];
      head_ready_i = V_RDY[i]; rob_empty_i = V_EMP[i]; head_seq_i = V_SEQ[i];
      #1;
      check(V_REQ[i], sel_valid_o, V_VAL[i]);
      check(V_REQ[i], sel_tid_o, V_TID[i]);
    end

    // R5 fairness: all ready, two full rounds
    for (int k = 0; k < 2 * N; k++) rr_step("R5", 4'hF, 1'b1);

    // R5 with thread 1 held back, then released
    for (int k = 0; k < 3; k++) rr_step("R5", 4'hD, 1'b1);
    rr_step("R5", 4'hF, 1'b1);

    // R6: idle queries, no-valid queries and oldest-ready queries leave the order
    rr_step("R6", 4'hF, 1'b0);
    rr_step("R6", 4'h0, 1'b1);
    @(negedge clk);
    policy_i = 2'd2; query_i = 1'b1; head_ready_i = 4'hF; head_seq_i = V_SEQ[0];
    #1;
    check("R6", sel_tid_o, 2);
    @(posedge clk);
    rr_step("R6", 4'hF, 1'b0);
    rr_step("R4", 4'hF, 1'b1);
    query_i = 1'b0;

    // R7/R8 random age ordering
    for (int k = 0; k < 300; k++) begin
      int bt;
      logic [SW-1:0] bs;
      @(negedge clk);
      query_i = 1'b0;
      policy_i = (k % 3 == 0) ? 2'd0 : ((k % 3 == 1) ? 2'd2 : 2'd3);
      for (int t = 0; t < N; t++) begin
        status_i[t] = 3'($urandom_range(0, 7));
        head_ready_i[t] = ($urandom_range(0, 3) != 0);
        rob_empty_i[t] = ($urandom_range(0, 5) == 0);
        head_seq_i[t] = SW'($urandom_range(0, 15));
      end
      bt = -1; bs = '0;
      for (int t = 0; t < N; t++) begin
        if ((status_i[t] == 3'd0 || status_i[t] == 3'd1 || status_i[t] == 3'd4) &&
            head_ready_i[t] && !rob_empty_i[t] && (bt < 0 || head_seq_i[t] < bs)) begin
          bt = t; bs = head_seq_i[t];
        end
      end
      #1;
      check("R7", sel_valid_o, (bt < 0) ? 0 : 1);
      check("R8", sel_tid_o, (bt < 0) ? 0 : bt);
    end

    // R10: single thread ignores ready/empty, obeys status
    @(negedge clk);
    s1_status[0] = 3'd1; s1_ready = 1'b0; s1_empty = 1'b1;
    #1;
    check("R10", s1_valid, 1);
    check("R10", s1_tid, 0);
    @(negedge clk);
    s1_status[0] = 3'd4;
    #1;
    check("R10", s1_valid, 1);
    @(negedge clk);
    s1_status[0] = 3'd2; s1_ready = 1'b1; s1_empty = 1'b0;
    #1;
    check("R10", s1_valid, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule